// File: doc/BRIEF.md
# Top-Core Slot Scheduler

This block decides which core owns a shared memory port in each clock cycle. Ownership rotates through the cores in index order. The length of the rotation is not fixed. It is the smallest power of two that still reaches the highest-numbered core that is running. A system that uses only the low-numbered cores therefore reaches the port more often, and no configuration register is involved. The period depends only on the top running index and not on how many cores are running. For example, if only core 5 runs, the rotation is 8 slots long.

A slot counter steps once per clock and returns to zero after the last slot of the current period. The period mask is worked out all the time from the running vector. It is loaded only when the counter returns to zero, so a core that starts or stops never cuts a rotation short or repeats a slot. The block shows the current owner's index every cycle. It raises a grant strobe when that owner is both running and asking for the port. The owner index and the grant are plain control outputs: there is no handshake and no back-pressure, and a core that misses its slot waits for the next one.

Top module: `topcore_slot_sched`

## Requirements
- R1: While reset is asserted, the owner index is 0. The first cycle after reset release also shows owner 0.
- R2: Within a period, the owner index rises by exactly one per clock. After the last slot of the period it returns to 0.
- R3: The period (cycles between consecutive owner-0 slots) follows the top running index: index 0 gives 1, index 1 gives 2, indices 2–3 give 4, indices 4–7 give 8, and indices 8–15 give 16.
- R4: Only the highest running index sets the period. Lower running or idle cores do not change it (core 5 alone gives 8; cores 2 and 8 give 16; core 3 alone gives 4).
- R5: The running vector is sampled for a new period only at the clock edge where the owner sits on the last slot. A change made mid-period lets the old rotation finish, and the new period starts with owner 0.
- R6: The grant is high in a cycle exactly when bit `slot_owner` of both `core_run` and `core_req` is 1 in that same cycle. It is combinational, with no register delay.
- R7: With a stable running set, every running core owns the port at least once in every 16 consecutive cycles. A core that stays running is never left without ownership for more than 31 consecutive cycles, even across period changes.
- R8: With no core running, the owner settles to 0 and stays there, and the grant stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_run | input | NUM_CORES | Bit i is 1 while core i is running |
| core_req | input | NUM_CORES | Bit i is 1 while core i wants the port |
| slot_owner | output | log2(NUM_CORES) | Index of the core that owns the current slot |
| slot_grant | output | 1 | The owner is running and requesting in this cycle |

## Verification
Some rules are checked on every cycle: the owner steps by one or returns to zero, a grant never goes to a core that is idle or not requesting, there is no grant while the whole set is idle, and no running core waits more than 31 cycles for its slot. Other behaviour can only be shown by the bench's scenarios, which compare against an independent reference model on every clock. These include the exact period for each top index, the rule that core count does not matter, and the deferral of a running-set change until the wrap.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

  // Width of an index able to name n cores (at least one bit).
  function automatic int idx_width(input int n);
    int w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction

endpackage

// File: rtl/sched_top_finder.sv
// Finds the highest set bit of the running vector; 0 when none is set.
module sched_top_finder #(
  parameter int N = 16,
  parameter int W = slot_sched_pkg::idx_width(N)
) (
  input  logic [N-1:0] run_vec,
  output logic [W-1:0] top_idx
);

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (run_vec[i]) top_idx = W'(i);
    end
  end

endmodule

// File: rtl/sched_mask_gen.sv
// Smears the top index downward: bit b is set when any index bit at or
// above b is set, giving (next power of two above the index) - 1.
module sched_mask_gen #(
  parameter int W = 4
) (
  input  logic [W-1:0] top_idx,
  output logic [W-1:0] period_mask
);

  for (genvar b = 0; b < W; b++) begin : g_smear
    assign period_mask[b] = |top_idx[W-1:b];
  end

endmodule

// File: rtl/sched_slot_counter.sv
// Slot counter with a period mask that is loaded only on wrap.
module sched_slot_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] next_mask,
  output logic [W-1:0] slot,
  output logic [W-1:0] live_mask
);

  logic at_last;

  assign at_last = ((slot & live_mask) == live_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot      <= '0;
      live_mask <= '0;
    end else if (at_last) begin
      slot      <= '0;
      live_mask <= next_mask;
    end else begin
      slot      <= slot + W'(1);
    end
  end

endmodule

// File: rtl/sched_grant_sel.sv
// Grant: owner of the slot is running and requesting.
module sched_grant_sel #(
  parameter int N = 16,
  parameter int W = slot_sched_pkg::idx_width(N)
) (
  input  logic [N-1:0] run_vec,
  input  logic [N-1:0] req_vec,
  input  logic [W-1:0] slot,
  output logic         grant
);

  always_comb begin
    grant = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (slot == W'(i)) grant = run_vec[i] & req_vec[i];
    end
  end

endmodule

// File: rtl/topcore_slot_sched.sv
module topcore_slot_sched #(
  parameter int NUM_CORES = 16,
  localparam int IDX_W = slot_sched_pkg::idx_width(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] core_run,
  input  logic [NUM_CORES-1:0] core_req,
  output logic [IDX_W-1:0]     slot_owner,
  output logic                 slot_grant
);

  logic [IDX_W-1:0] top_idx;
  logic [IDX_W-1:0] wanted_mask;
  logic [IDX_W-1:0] live_mask;

  sched_top_finder #(.N(NUM_CORES), .W(IDX_W)) u_top (
    .run_vec (core_run),
    .top_idx (top_idx)
  );

  sched_mask_gen #(.W(IDX_W)) u_mask (
    .top_idx     (top_idx),
    .period_mask (wanted_mask)
  );

  sched_slot_counter #(.W(IDX_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .next_mask (wanted_mask),
    .slot      (slot_owner),
    .live_mask (live_mask)
  );

  sched_grant_sel #(.N(NUM_CORES), .W(IDX_W)) u_gnt (
    .run_vec (core_run),
    .req_vec (core_req),
    .slot    (slot_owner),
    .grant   (slot_grant)
  );

endmodule

// File: rtl/topcore_slot_sched_chk.sv
module topcore_slot_sched_chk #(
  parameter int NUM_CORES = 16,
  localparam int IDX_W = slot_sched_pkg::idx_width(NUM_CORES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CORES-1:0] core_run,
  input logic [NUM_CORES-1:0] core_req,
  input logic [IDX_W-1:0]     slot_owner,
  input logic                 slot_grant
);

  // R2: owner either steps by one or returns to zero
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_owner != '0) |-> (slot_owner == IDX_W'($past(slot_owner) + 1'b1)));

  // R6: a grant always belongs to a running, requesting owner
  a_r6_grant_run: assert property (@(posedge clk) disable iff (!rst_n)
    slot_grant |-> core_run[slot_owner]);
  a_r6_grant_req: assert property (@(posedge clk) disable iff (!rst_n)
    slot_grant |-> core_req[slot_owner]);

  // R8: no grant while every core is idle
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (core_run == '0) |-> !slot_grant);

  // R7: waiting-time bound per core, counted rather than unrolled
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_gap
    logic [5:0] gap;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gap <= '0;
      else if (!core_run[i] || slot_owner == IDX_W'(i)) gap <= '0;
      else if (gap != 6'd63) gap <= gap + 6'd1;
    end
    a_r7_gap: assert property (@(posedge clk) disable iff (!rst_n)
      gap <= 6'd31);
  end

endmodule

bind topcore_slot_sched topcore_slot_sched_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_run   (core_run),
  .core_req   (core_req),
  .slot_owner (slot_owner),
  .slot_grant (slot_grant)
);

// File: tb/topcore_slot_sched_test.sv
module topcore_slot_sched_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] core_run = '0;
  logic [15:0] core_req = '0;
  logic [3:0]  slot_owner;
  logic        slot_grant;

  int total = 0;
  int fails = 0;
  int m_slot = 0;
  int m_mask = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  topcore_slot_sched #(.NUM_CORES(16)) uut (
    .clk(clk), .rst_n(rst_n), .core_run(core_run), .core_req(core_req),
    .slot_owner(slot_owner), .slot_grant(slot_grant)
  );

  function automatic int ref_mask(input logic [15:0] r);
    int h = -1;
    int p = 1;
    for (int i = 0; i < 16; i++) if (r[i]) h = i;
    if (h < 0) return 0;
    while (p < h + 1) p = p * 2;
    return p - 1;
  endfunction

  // Behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_slot = 0; m_mask = 0;
    end else if (m_slot == m_mask) begin
      m_slot = 0; m_mask = ref_mask(core_run);
    end else begin
      m_slot = m_slot + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] r, input logic [15:0] q);
    int eg;
    @(negedge clk);
    core_run = r; core_req = q;
    #1;
    chk(int'(slot_owner) == m_slot, "R2 owner vs model", int'(slot_owner), m_slot);
    eg = (r[m_slot] && q[m_slot]) ? 1 : 0;
    chk(int'(slot_grant) == eg, "R6 grant vs model", int'(slot_grant), eg);
  endtask

  task automatic measure(input logic [15:0] r, input int exp, input string tag);
    int first = -1;
    int second = -1;
    repeat (40) step(r, 16'hFFFF);
    for (int k = 0; k < 40; k++) begin
      step(r, 16'hFFFF);
      if (slot_owner == 4'd0) begin
        if (first < 0) first = k;
        else if (second < 0) second = k;
      end
    end
    chk(second - first == exp, tag, second - first, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; total++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bit ok;
    int grants;
    int last0, last15, gmax;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(slot_owner == 4'd0, "R1 owner in reset", int'(slot_owner), 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(slot_owner == 4'd0, "R1 owner after release", int'(slot_owner), 0);

    // R8: idle set
    grants = 0;
    for (int k = 0; k < 20; k++) begin
      step(16'h0000, 16'hFFFF);
      grants += int'(slot_grant);
    end
    chk(grants == 0, "R8 idle grants", grants, 0);
    chk(slot_owner == 4'd0, "R8 idle owner", int'(slot_owner), 0);

    // R3: period per top index
    measure(16'h0001, 1,  "R3 period top0");
    measure(16'h0003, 2,  "R3 period top1");
    measure(16'h0007, 4,  "R3 period top2");
    measure(16'h001F, 8,  "R3 period top4");
    measure(16'hFFFF, 16, "R3 period top15");
    // R4: highest index, not count
    measure(16'h0020, 8,  "R4 core5 alone");
    measure(16'h0104, 16, "R4 cores2 and 8");
    measure(16'h0008, 4,  "R4 core3 alone");

    // R6: request patterns
    repeat (32) step(16'hFFFF, 16'hAAAA);
    grants = 0;
    for (int k = 0; k < 32; k++) begin
      step(16'hFFFF, 16'hAAAA);
      grants += int'(slot_grant);
    end
    chk(grants == 16, "R6 odd requests", grants, 16);
    repeat (32) step(16'h00F0, 16'hFFFF);
    grants = 0;
    for (int k = 0; k < 32; k++) begin
      step(16'h00F0, 16'hFFFF);
      grants += int'(slot_grant);
    end
    chk(grants == 16, "R6 cores4-7 running", grants, 16);

    // R7: stable gap of 16 for cores 0 and 15
    repeat (32) step(16'h8001, 16'hFFFF);
    last0 = -1; last15 = -1; gmax = 0;
    for (int k = 0; k < 48; k++) begin
      step(16'h8001, 16'hFFFF);
      if (slot_owner == 4'd0) begin
        if (last0 >= 0 && k - last0 > gmax) gmax = k - last0;
        last0 = k;
      end
      if (slot_owner == 4'd15) begin
        if (last15 >= 0 && k - last15 > gmax) gmax = k - last15;
        last15 = k;
      end
    end
    chk(gmax == 16, "R7 stable gap", gmax, 16);

    // R5: shrink mid-period, old rotation finishes first
    for (int k = 0; k < 40 && slot_owner != 4'd2; k++) step(16'hFFFF, 16'hFFFF);
    chk(slot_owner == 4'd2, "R5 reached slot2", int'(slot_owner), 2);
    ok = 1'b1;
    for (int k = 3; k <= 15; k++) begin
      step(16'h0001, 16'hFFFF);
      if (int'(slot_owner) != k) ok = 1'b0;
    end
    chk(ok, "R5 old period completes", int'(ok), 1);
    step(16'h0001, 16'hFFFF);
    step(16'h0001, 16'hFFFF);
    chk(slot_owner == 4'd0, "R5 new period of one", int'(slot_owner), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule